// File: doc/BRIEF.md
# Dual-Width Flag Adder with Tag Check

This block is a 64-bit integer adder. In one combinational pass it produces the sum and two sets of condition flags. One set describes the low 32-bit word of the result and the other describes the full 64-bit result. A registered flag store keeps both sets between operations, and add-with-carry reads its carry-in from that store.

A 2-bit operation code selects the operation. The codes are: plain add with no flag write; add; add-with-carry; and tagged add. A tagged add treats the two least significant bits of each operand as a type tag. A nonzero tag on either operand marks the 32-bit result as overflowed.

The store is written on a rising clock edge only when the update enable is high and the operation code is not plain add. Both flag sets use the nibble layout {N, Z, V, C}, with N in bit 3 and C in bit 0.

Top module: `tagged_flag_adder`

## Requirements
- R1: `sum` equals `a + b + cin` modulo 2^64. `cin` is 0 for every code except 2'b10.
- R2: With code 2'b10 (add-with-carry), the carry-in is the stored 32-bit carry flag, `flg_lo_q[0]`.
- R3: `flg_hi[0]` (64-bit C) is the carry out of bit 63 of the full sum, carry-in included.
- R4: `flg_lo[0]` (32-bit C) is the carry into bit 32, which is bit 32 of `sum ^ a ^ b`.
- R5: `flg_lo[1]` is the signed overflow of the low 32-bit word. `flg_hi[1]` is the signed overflow of the 64-bit value. In each case overflow means the operands have equal sign bits and the result's sign bit differs from them.
- R6: `flg_lo[3]`/`flg_hi[3]` are bit 31/bit 63 of `sum`. `flg_lo[2]` is 1 when `sum[31:0]` is zero, and `flg_hi[2]` is 1 when the whole of `sum` is zero.
- R7: With code 2'b11 (tagged add), `flg_lo[1]` is forced to 1 when `a[1:0] | b[1:0]` is nonzero. `flg_hi[1]` is not affected.
- R8: On a rising edge with `upd_en` high and a code other than 2'b00, the store loads `flg_lo`/`flg_hi`. In every other case the store holds its value; this includes code 2'b00 with `upd_en` high.
- R9: A synchronous reset clears all eight stored flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag store |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 2 | Operation: 00 plain add, 01 add, 10 add-with-carry, 11 tagged add |
| upd_en | input | 1 | Flag store write enable |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| sum | output | 64 | Result |
| flg_lo | output | 4 | Current 32-bit flags {N,Z,V,C} |
| flg_hi | output | 4 | Current 64-bit flags {N,Z,V,C} |
| flg_lo_q | output | 4 | Stored 32-bit flags |
| flg_hi_q | output | 4 | Stored 64-bit flags |

## Verification
The bench targets operand pairs where the two flag sets disagree:
- `0xFFFFFFFF + 1` sets the 32-bit carry and zero flags but neither 64-bit flag. A design that took the 32-bit carry from the wrong bit would miss this.
- `0x7FFFFFFF + 1` overflows only the low word.
- The largest positive 64-bit value plus one overflows only the full width.

For add-with-carry, the bench first sets the stored carry and then checks that the extra one reaches the sum. It also checks that it ripples into the upper word. A design that read the 64-bit carry instead would produce a different sum.

Tagged adds are run both with and without tag bits set, to confirm that only the 32-bit overflow flag is affected. A series of stores attempted with code 00 or with the enable low then confirms that the stored flags do not move.

// File: rtl/tagged_flag_adder.sv
module tagged_flag_adder #(
  parameter int W    = 64,
  parameter int TAGW = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   op,
  input  logic         upd_en,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic [3:0]   flg_lo,
  output logic [3:0]   flg_hi,
  output logic [3:0]   flg_lo_q,
  output logic [3:0]   flg_hi_q
);
  localparam int H = W / 2;

  logic         cin;
  logic [W:0]   wide;
  logic         tag_bad;
  logic         c_mid;
  logic         v_lo;
  logic         v_hi;

  assign cin  = (op == 2'b10) & flg_lo_q[0];
  assign wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign sum  = wide[W-1:0];

  assign c_mid   = sum[H] ^ a[H] ^ b[H];
  assign v_lo    = (sum[H-1] ^ b[H-1]) & ~(a[H-1] ^ b[H-1]);
  assign v_hi    = (sum[W-1] ^ b[W-1]) & ~(a[W-1] ^ b[W-1]);
  assign tag_bad = (op == 2'b11) & (|(a[TAGW-1:0] | b[TAGW-1:0]));

  assign flg_lo = {sum[H-1], ~|sum[H-1:0], v_lo | tag_bad, c_mid};
  assign flg_hi = {sum[W-1], ~|sum, v_hi, wide[W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_lo_q <= 4'h0;
      flg_hi_q <= 4'h0;
    end else if (upd_en && op != 2'b00) begin
      flg_lo_q <= flg_lo;
      flg_hi_q <= flg_hi;
    end
  end
endmodule

// File: rtl/tagged_flag_adder_chk.sv
module tagged_flag_adder_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   op,
  input logic         upd_en,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] sum,
  input logic [3:0]   flg_lo,
  input logic [3:0]   flg_hi,
  input logic [3:0]   flg_lo_q,
  input logic [3:0]   flg_hi_q
);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(upd_en && op != 2'b00) |=> $stable(flg_lo_q) && $stable(flg_hi_q));

  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op != 2'b00) |=> flg_lo_q == $past(flg_lo) && flg_hi_q == $past(flg_hi));

  p_tag_v_r7: assert property (@(posedge clk) disable iff (rst)
    (op == 2'b11 && (|(a[1:0] | b[1:0]))) |-> flg_lo[1]);

  p_no_cin_r1: assert property (@(posedge clk) disable iff (rst)
    (op != 2'b10) |-> sum == a + b);

  p_carry_out_r3: assert property (@(posedge clk) disable iff (rst)
    (op != 2'b10 && a[W-1] && b[W-1]) |-> flg_hi[0]);
endmodule

bind tagged_flag_adder tagged_flag_adder_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .op(op), .upd_en(upd_en), .a(a), .b(b), .sum(sum),
  .flg_lo(flg_lo), .flg_hi(flg_hi), .flg_lo_q(flg_lo_q), .flg_hi_q(flg_hi_q)
);

// File: tb/tagged_flag_adder_tb_top.sv
module tagged_flag_adder_tb_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  op = 2'b00;
  logic        upd_en = 1'b0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic [63:0] sum;
  logic [3:0]  flg_lo, flg_hi, flg_lo_q, flg_hi_q;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] m_lo = 4'h0;
  logic [3:0] m_hi = 4'h0;

  always #(PERIOD/2) clk = ~clk;

  tagged_flag_adder dut_i (
    .clk(clk), .rst(rst), .op(op), .upd_en(upd_en), .a(a), .b(b), .sum(sum),
    .flg_lo(flg_lo), .flg_hi(flg_hi), .flg_lo_q(flg_lo_q), .flg_hi_q(flg_hi_q)
  );

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] o, input logic u, input logic [63:0] x, input logic [63:0] y);
    logic        ci;
    logic [64:0] w;
    logic [32:0] lw;
    logic [63:0] s;
    logic [3:0]  e_lo, e_hi;
    @(negedge clk);
    op = o; upd_en = u; a = x; b = y;
    #1;
    ci = (o == 2'b10) ? m_lo[0] : 1'b0;
    w  = {1'b0, x} + {1'b0, y} + 65'(ci);
    lw = {1'b0, x[31:0]} + {1'b0, y[31:0]} + 33'(ci);
    s  = w[63:0];
    e_lo[3] = s[31];
    e_lo[2] = (s[31:0] == 32'd0);
    e_lo[1] = (x[31] == y[31]) && (s[31] != x[31]);
    if (o == 2'b11 && (x[1:0] != 2'b00 || y[1:0] != 2'b00)) e_lo[1] = 1'b1;
    e_lo[0] = lw[32];
    e_hi[3] = s[63];
    e_hi[2] = (s == 64'd0);
    e_hi[1] = (x[63] == y[63]) && (s[63] != x[63]);
    e_hi[0] = w[64];
    cmp("R1/R2 sum", sum, s);
    cmp("R4/R5/R6/R7 flg_lo", 64'(flg_lo), 64'(e_lo));
    cmp("R3/R5/R6/R7 flg_hi", 64'(flg_hi), 64'(e_hi));
    @(posedge clk);
    if (u && o != 2'b00) begin m_lo = e_lo; m_hi = e_hi; end
    #1;
    cmp("R8 stored", 64'({flg_lo_q, flg_hi_q}), 64'({m_lo, m_hi}));
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cmp("R9 reset", 64'({flg_lo_q, flg_hi_q}), 64'h0);
    @(negedge clk); rst = 1'b0;
    step(2'b01, 1'b1, 64'd0, 64'd0);
    step(2'b01, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    step(2'b01, 1'b1, 64'h0000_0000_7FFF_FFFF, 64'd1);
    step(2'b01, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
    step(2'b01, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'd1);
    step(2'b10, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'd0);
    step(2'b01, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'd1);
    step(2'b10, 1'b0, 64'h0000_0001_0000_0000, 64'd5);
    step(2'b00, 1'b1, 64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000);
    step(2'b11, 1'b1, 64'h0000_0000_0000_0004, 64'h0000_0000_0000_0008);
    step(2'b11, 1'b1, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0008);
    step(2'b11, 1'b1, 64'h7FFF_FFFF_FFFF_FFFE, 64'h0000_0000_0000_0006);
    step(2'b01, 1'b0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
    for (int i = 0; i < 300; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (i % 4 == 0) rb = ~ra;
      step(2'($urandom), 1'($urandom), ra, rb);
    end
    step(2'b01, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    m_lo = 4'h0; m_hi = 4'h0;
    cmp("R9 reset clears", 64'({flg_lo_q, flg_hi_q}), 64'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule